// File: doc/BRIEF.md
# Speed Discriminator with Lock Flag

This block measures the rotation speed of a motor and judges it against a programmable target. The speed pulse from the motor sensor is divided by a selectable power of two. The time between divided edges is then counted in ticks of a reference clock, which is itself prescaled by a selectable power of two. The result is the measured period. It is compared with a 12-bit target count, and the comparison drives a loop filter through two pulse outputs. `speed_up` means the motor is too slow. `speed_down` means the motor is too fast. Each pulse is as wide as the count error.

Every finished measurement also refreshes an active-low lock flag. The flag is asserted when the measured count lies within a tolerance band around the target, and the band is selectable as roughly 6% or 3% of the target. At lock, the reference clock frequency equals the divided speed-edge rate times the reference divider times the target count. Any speed therefore follows from the choice of target and dividers, and the external loop filter needs no change.

Top module: `speed_discriminator`

## Requirements
- R1: While reset is applied and after it is released, `speed_up` and `speed_down` are 0, `lock_n` is 1 and `period_cnt` is 0 until a measurement completes.
- R2: Each divider select maps code 00 to 1, 01 to 2, 10 to 4 and 11 to 8, with bit 0 as the LSB. A measurement ends on every Nth rising edge of `spd_in`, where N comes from `spd_div_sel`. The reference tick fires once every M clock cycles, where M comes from `ref_div_sel`. The measured count is the number of ticks from one measurement end, inclusive, to the next, exclusive.
- R3: The running count stops at 4095. A measurement that ends at 4095 reports 4095, counts as too slow (a `speed_up` pulse of at least one tick) and leaves `lock_n` high.
- R4: A `target_cnt` below 1024 is treated as 1024.
- R5: At each measurement, `lock_n` goes low when the count lies within T ± (T >> 4) if `narrow_win` is 0, or within T ± (T >> 5) if `narrow_win` is 1, with both bounds inclusive and T the effective target. Otherwise `lock_n` goes high.
- R6: The first measurement end after reset only starts counting. `period_cnt` changes only in the cycle after a measurement end.
- R7: A count above T gives a `speed_up` pulse, and a count below T gives a `speed_down` pulse. Either pulse lasts |count − T| reference ticks, capped at the measured count, and starts the cycle after the measurement. A new measurement replaces a pulse that is still running. The two pulses are never high together.
- R8: When no speed edge arrives and the running count sits at 4095, `lock_n` goes high without waiting for the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spd_in | input | 1 | Motor speed pulse |
| spd_div_sel | input | 2 | Speed edge divider code |
| ref_div_sel | input | 2 | Reference tick prescaler code |
| target_cnt | input | 12 | Target count per measurement |
| narrow_win | input | 1 | 1 selects the narrow lock band, 0 the wide band |
| speed_up | output | 1 | Too-slow correction pulse |
| speed_down | output | 1 | Too-fast correction pulse |
| lock_n | output | 1 | Active-low lock flag |
| period_cnt | output | 12 | Last measured count |

## Verification
The assertions assume that `spd_in` stays high and low for at least one clock each, so that the synchroniser registers every rising edge. They also assume that the selects and the target change only between pulse trains, so that a pulse that is still running was started by a measurement under the current settings. The stimulus drives every input half a cycle away from the sampling edge. It holds the pulse high for two cycles of each period and changes settings only at the start of a new train. Each scenario runs at least two measurements under the new settings before any result is checked.

// File: rtl/spd_disc_pkg.sv
package spd_disc_pkg;
  localparam int unsigned CNT_W         = 12;
  localparam int unsigned SEL_W         = 2;
  localparam int unsigned DIVC_W        = (1 << SEL_W) - 1;
  localparam int unsigned C_FLOOR       = 1024;
  localparam int unsigned WIN_SH_WIDE   = 4;
  localparam int unsigned WIN_SH_NARROW = 5;
  localparam int unsigned SYNC_STAGES   = 2;

  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX = '1;

  // code k selects a divide-by-2^k; returns the terminal count 2^k - 1
  function automatic logic [DIVC_W-1:0] div_mask(input logic [SEL_W-1:0] code);
    return DIVC_W'((1 << code) - 1);
  endfunction
endpackage

// File: rtl/spd_pow2_div.sv
module spd_pow2_div
  import spd_disc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [SEL_W-1:0] sel,
  output logic             strobe
);
  logic [DIVC_W-1:0] cnt_q;
  logic [DIVC_W-1:0] cnt_d;
  logic [DIVC_W-1:0] mask;

  assign mask   = div_mask(sel);
  assign strobe = inc && (cnt_q >= mask);

  always_comb begin
    cnt_d = cnt_q;
    if (inc) begin
      cnt_d = strobe ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/spd_period_counter.sv
module spd_period_counter
  import spd_disc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ev,
  output cnt_t run_cnt,
  output cnt_t meas_cnt,
  output logic sat,
  output logic valid
);
  cnt_t cnt_q, cnt_d;
  cnt_t meas_q, meas_d;
  logic armed_q, armed_d;

  assign run_cnt  = cnt_q;
  assign meas_cnt = meas_q;
  assign sat      = (cnt_q == CNT_MAX);
  assign valid    = ev && armed_q;

  always_comb begin
    cnt_d   = cnt_q;
    meas_d  = meas_q;
    armed_d = armed_q;
    if (ev) begin
      cnt_d   = tick ? cnt_t'(1) : '0;
      armed_d = 1'b1;
      if (armed_q) begin
        meas_d = cnt_q;
      end
    end else if (tick && !sat) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      meas_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      meas_q  <= meas_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/spd_judge.sv
module spd_judge
  import spd_disc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic valid,
  input  logic sat,
  input  cnt_t run_cnt,
  input  cnt_t target,
  input  logic narrow,
  output logic up,
  output logic down,
  output logic lock_n
);
  cnt_t           ceff, half, lo, raw, width;
  logic [CNT_W:0] hi;
  logic           in_win, over;
  cnt_t           pw_q, pw_d;
  logic           dir_q, dir_d;
  logic           lk_q, lk_d;

  assign ceff   = (target < cnt_t'(C_FLOOR)) ? cnt_t'(C_FLOOR) : target;
  assign half   = narrow ? (ceff >> WIN_SH_NARROW) : (ceff >> WIN_SH_WIDE);
  assign lo     = ceff - half;
  assign hi     = {1'b0, ceff} + {1'b0, half};
  assign in_win = !sat && (run_cnt >= lo) && ({1'b0, run_cnt} <= hi);
  assign over   = sat || (run_cnt > ceff);

  always_comb begin
    raw = over ? (run_cnt - ceff) : (ceff - run_cnt);
    if (sat && (raw == '0)) begin
      raw = cnt_t'(1);
    end
    width = (raw > run_cnt) ? run_cnt : raw;
  end

  always_comb begin
    pw_d  = pw_q;
    dir_d = dir_q;
    lk_d  = lk_q;
    if (valid) begin
      pw_d  = width;
      dir_d = over;
      lk_d  = !in_win;
    end else begin
      if (tick && (pw_q != '0)) begin
        pw_d = pw_q - 1'b1;
      end
      if (sat) begin
        lk_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q  <= '0;
      dir_q <= 1'b0;
      lk_q  <= 1'b1;
    end else begin
      pw_q  <= pw_d;
      dir_q <= dir_d;
      lk_q  <= lk_d;
    end
  end

  assign up     = (pw_q != '0) && dir_q;
  assign down   = (pw_q != '0) && !dir_q;
  assign lock_n = lk_q;
endmodule

// File: rtl/speed_discriminator.sv
module speed_discriminator
  import spd_disc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spd_in,
  input  logic [SEL_W-1:0] spd_div_sel,
  input  logic [SEL_W-1:0] ref_div_sel,
  input  logic [CNT_W-1:0] target_cnt,
  input  logic             narrow_win,
  output logic             speed_up,
  output logic             speed_down,
  output logic             lock_n,
  output logic [CNT_W-1:0] period_cnt
);
  logic [1:0]           rs_q;
  logic                 rst_core_n;
  logic [SYNC_STAGES:0] sync_q;
  logic                 spd_rise;
  logic                 ref_tick;
  logic                 meas_ev;
  cnt_t                 run_cnt;
  logic                 cnt_sat;
  logic                 meas_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_core_n = rs_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], spd_in};
    end
  end
  assign spd_rise = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

  spd_pow2_div u_refdiv (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .inc    (1'b1),
    .sel    (ref_div_sel),
    .strobe (ref_tick)
  );

  spd_pow2_div u_spddiv (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .inc    (spd_rise),
    .sel    (spd_div_sel),
    .strobe (meas_ev)
  );

  spd_period_counter u_period (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (ref_tick),
    .ev       (meas_ev),
    .run_cnt  (run_cnt),
    .meas_cnt (period_cnt),
    .sat      (cnt_sat),
    .valid    (meas_valid)
  );

  spd_judge u_judge (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (ref_tick),
    .valid   (meas_valid),
    .sat     (cnt_sat),
    .run_cnt (run_cnt),
    .target  (target_cnt),
    .narrow  (narrow_win),
    .up      (speed_up),
    .down    (speed_down),
    .lock_n  (lock_n)
  );
endmodule

// File: rtl/spd_disc_checker.sv
module spd_disc_checker
  import spd_disc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic ev,
  input cnt_t run_cnt,
  input cnt_t meas_cnt,
  input logic up,
  input logic down,
  input logic lock_n
);
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && down));

  p_meas_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev |=> $stable(meas_cnt));

  p_lock_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> $past(ev));

  p_pulse_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(up) || $rose(down)) |-> $past(ev));

  p_sat_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == CNT_MAX && !ev) |=> lock_n);

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == CNT_MAX && !ev) |=> (run_cnt == CNT_MAX));
endmodule

bind speed_discriminator spd_disc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .ev       (meas_ev),
  .run_cnt  (run_cnt),
  .meas_cnt (period_cnt),
  .up       (speed_up),
  .down     (speed_down),
  .lock_n   (lock_n)
);

// File: tb/sim_speed_discriminator.sv
`timescale 1ns/1ps
module sim_speed_discriminator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        spd_in;
  logic [1:0]  spd_div_sel;
  logic [1:0]  ref_div_sel;
  logic [11:0] target_cnt;
  logic        narrow_win;
  logic        speed_up, speed_down, lock_n;
  logic [11:0] period_cnt;

  int compared = 0;
  int mismatched = 0;
  int up_seen = 0;
  int dn_seen = 0;
  string cur_req = "R1";

  // reference model state
  int m_s1, m_s2, m_a, m_b, m_c, m_ecnt, m_pcnt, m_cnt, m_armed, m_meas, m_pw, m_dir, m_lk;

  always #2.5 clk = ~clk;

  speed_discriminator u0 (
    .clk(clk), .rst_n(rst_n), .spd_in(spd_in), .spd_div_sel(spd_div_sel),
    .ref_div_sel(ref_div_sel), .target_cnt(target_cnt), .narrow_win(narrow_win),
    .speed_up(speed_up), .speed_down(speed_down), .lock_n(lock_n), .period_cnt(period_cnt)
  );

  task automatic model_step();
    int rise, ev, tick, sat, valid, ceff, half, raw, over, inwin;
    int n_ecnt, n_pcnt, n_cnt, n_armed, n_meas, n_pw, n_dir, n_lk;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_a = 0; m_b = 0; m_c = 0; m_ecnt = 0; m_pcnt = 0;
      m_cnt = 0; m_armed = 0; m_meas = 0; m_pw = 0; m_dir = 0; m_lk = 1;
      return;
    end
    if (m_s2 != 0) begin
      rise = (m_b != 0 && m_c == 0) ? 1 : 0;
      ev   = (rise != 0 && m_ecnt >= (1 << spd_div_sel) - 1) ? 1 : 0;
      tick = (m_pcnt >= (1 << ref_div_sel) - 1) ? 1 : 0;
      sat  = (m_cnt == 4095) ? 1 : 0;
      valid = (ev != 0 && m_armed != 0) ? 1 : 0;
      ceff = (target_cnt < 1024) ? 1024 : int'(target_cnt);
      half = narrow_win ? (ceff >> 5) : (ceff >> 4);
      n_ecnt = m_ecnt; n_pcnt = tick ? 0 : m_pcnt + 1; n_cnt = m_cnt;
      n_armed = m_armed; n_meas = m_meas; n_pw = m_pw; n_dir = m_dir; n_lk = m_lk;
      if (rise != 0) n_ecnt = ev ? 0 : m_ecnt + 1;
      if (valid != 0) begin
        over = (sat != 0 || m_cnt > ceff) ? 1 : 0;
        raw  = over ? m_cnt - ceff : ceff - m_cnt;
        if (sat != 0 && raw == 0) raw = 1;
        n_pw = (raw > m_cnt) ? m_cnt : raw;
        n_dir = over;
        inwin = (sat == 0 && m_cnt >= ceff - half && m_cnt <= ceff + half) ? 1 : 0;
        n_lk = inwin ? 0 : 1;
        n_meas = m_cnt;
      end else begin
        if (tick != 0 && m_pw > 0) n_pw = m_pw - 1;
        if (sat != 0) n_lk = 1;
      end
      if (ev != 0) begin
        n_cnt = tick ? 1 : 0;
        n_armed = 1;
      end else if (tick != 0 && sat == 0) begin
        n_cnt = m_cnt + 1;
      end
      m_c = m_b; m_b = m_a; m_a = spd_in;
      m_ecnt = n_ecnt; m_pcnt = n_pcnt; m_cnt = n_cnt; m_armed = n_armed;
      m_meas = n_meas; m_pw = n_pw; m_dir = n_dir; m_lk = n_lk;
    end
    m_s2 = m_s1;
    m_s1 = 1;
  endtask

  task automatic cmp(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    model_step();
    #1;
    cmp("speed_up", int'(speed_up), (m_pw > 0 && m_dir != 0) ? 1 : 0);
    cmp("speed_down", int'(speed_down), (m_pw > 0 && m_dir == 0) ? 1 : 0);
    cmp("lock_n", int'(lock_n), m_lk);
    cmp("period_cnt", int'(period_cnt), m_meas);
    if (speed_up) up_seen++;
    if (speed_down) dn_seen++;
  end

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic train(int p, int n);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        spd_in = (c < 2);
      end
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      spd_in = 1'b0;
    end
  endtask

  task automatic count_one(int p);
    up_seen = 0;
    dn_seen = 0;
    train(p, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; spd_in = 1'b0; spd_div_sel = 2'b00; ref_div_sel = 2'b00;
    target_cnt = 12'd2000; narrow_win = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1", "speed_up", int'(speed_up), 0);
    chk("R1", "speed_down", int'(speed_down), 0);
    chk("R1", "lock_n", int'(lock_n), 1);
    chk("R1", "period_cnt", int'(period_cnt), 0);
    rst_n = 1'b1;
    idle(10);
    chk("R1", "lock_n after release", int'(lock_n), 1);

    // R6: first edge only arms
    cur_req = "R6";
    train(2000, 1);
    chk("R6", "period_cnt after first edge", int'(period_cnt), 0);
    chk("R6", "lock_n after first edge", int'(lock_n), 1);
    cur_req = "R2";
    train(2000, 3);
    chk("R2", "period_cnt undivided", int'(period_cnt), 2000);
    chk("R5", "lock_n on target", int'(lock_n), 0);

    // R7: too slow and too fast
    cur_req = "R7";
    train(2300, 3);
    count_one(2300);
    chk("R7", "speed_up ticks", up_seen, 300);
    chk("R7", "speed_down ticks", dn_seen, 0);
    chk("R7", "period_cnt slow", int'(period_cnt), 2300);
    train(1800, 3);
    count_one(1800);
    chk("R7", "speed_down ticks", dn_seen, 200);
    chk("R7", "speed_up ticks", up_seen, 0);

    // R5: band edges
    cur_req = "R5";
    train(2125, 2);
    chk("R5", "wide upper edge", int'(lock_n), 0);
    train(2126, 2);
    chk("R5", "wide beyond edge", int'(lock_n), 1);
    narrow_win = 1'b1;
    train(2062, 2);
    chk("R5", "narrow upper edge", int'(lock_n), 0);
    train(2063, 2);
    chk("R5", "narrow beyond edge", int'(lock_n), 1);
    narrow_win = 1'b0;

    // R2: divider codes
    cur_req = "R2";
    spd_div_sel = 2'b10; ref_div_sel = 2'b01;
    train(1000, 12);
    chk("R2", "spd/4 ref/2", int'(period_cnt), 2000);
    chk("R2", "lock spd/4 ref/2", int'(lock_n), 0);
    spd_div_sel = 2'b01; ref_div_sel = 2'b10; target_cnt = 12'd1000;
    train(2000, 6);
    chk("R2", "spd/2 ref/4", int'(period_cnt), 1000);
    spd_div_sel = 2'b11; ref_div_sel = 2'b00; target_cnt = 12'd2000;
    train(250, 24);
    chk("R2", "spd/8 ref/1", int'(period_cnt), 2000);
    spd_div_sel = 2'b11; ref_div_sel = 2'b11; target_cnt = 12'd1100;
    train(1100, 24);
    chk("R2", "spd/8 ref/8", int'(period_cnt), 1100);
    spd_div_sel = 2'b00; ref_div_sel = 2'b00; target_cnt = 12'd2000;

    // R3: saturation
    cur_req = "R3";
    train(5000, 3);
    count_one(5000);
    chk("R3", "period_cnt saturated", int'(period_cnt), 4095);
    chk("R3", "speed_up ticks", up_seen, 2095);
    chk("R3", "lock_n saturated", int'(lock_n), 1);

    // R8: ready drops without an edge
    cur_req = "R8";
    train(2000, 3);
    chk("R8", "lock_n before stop", int'(lock_n), 0);
    idle(1500);
    chk("R8", "lock_n still held", int'(lock_n), 0);
    idle(1000);
    chk("R8", "lock_n after stall", int'(lock_n), 1);

    // R4: target floor
    cur_req = "R4";
    target_cnt = 12'd500;
    train(1024, 3);
    count_one(1024);
    chk("R4", "lock_n at floor", int'(lock_n), 0);
    chk("R4", "speed_down ticks", dn_seen, 0);
    train(1100, 2);
    count_one(1100);
    chk("R4", "speed_up ticks vs floor", up_seen, 76);
    chk("R4", "lock_n outside floor band", int'(lock_n), 1);

    // R7: width cap at measured count
    cur_req = "R7";
    target_cnt = 12'd4000;
    train(1500, 3);
    count_one(1500);
    chk("R7", "capped speed_down ticks", dn_seen, 1500);
    chk("R7", "capped speed_up ticks", up_seen, 0);

    idle(5);
    finish_run();
  end
endmodule